// File: doc/BRIEF.md
# Sleep and Wake-up Reset Controller

This block runs the low-power sleep mode of a small microcontroller core. A one-cycle sleep request from the instruction decoder stops the oscillator enable and pulses a watchdog clear. It also updates two status flags: the time-out flag is set and the power-down flag is cleared. The watchdog counter itself keeps running.

While asleep, four sources can end sleep:
- the external reset line, when it is configured as a reset;
- a watchdog time-out, when the watchdog is enabled;
- a change on the three monitored pins;
- a change on the comparator output.

A wake restores the oscillator enable, pulses the watchdog clear again and issues a fixed-length wake reset pulse to the core.

The pin monitor compares the pins against a reference that the core refreshes whenever it reads or writes the port. It does not compare against the pins at sleep entry. A mismatch left over from before sleep therefore wakes the core at once. The comparator monitor compares against the comparator value captured at sleep entry.

The block records the winning source as a cause code and keeps sticky pin and comparator wake flags. These survive the wake reset. A power-on reset or a software clear pulse removes them. All interfaces are plain control and status pins; no data stream passes through the block, so there is no valid/ready handshake.

Top module: `slp_wake_ctrl`

## Requirements
- R1: After power-on reset the outputs are: osc_en=1, pd_flag=1, to_flag=1, wake_rst=0, wdt_clr=0, pin_wake_flag=0, cmp_wake_flag=0 and wake_cause=0.
- R2: A sleep_req sampled while running has these effects in the following cycle: osc_en=0, to_flag=1, pd_flag=0, and wdt_clr high for exactly one cycle. pd_flag never rises again until power-on reset.
- R3: While asleep, ext_rst_n low with ext_rst_en=1 wakes the core with wake_cause=1. With ext_rst_en=0 the line is ignored.
- R4: While asleep, wdt_timeout with wdt_en=1 wakes the core with wake_cause=2 and clears to_flag. Any other wake source leaves to_flag at 1. With wdt_en=0 the time-out is ignored.
- R5: The pin reference is loaded from the synchronized pins on a port_access pulse while running, and it is frozen during sleep. While asleep with pin_wake_en=1, pins differing from the reference set pin_wake_flag and wake the core with wake_cause=3. With pin_wake_en=0 pin changes are ignored.
- R6: If the pins already differ from the reference when sleep is entered, the core wakes one cycle after entry with no pin change during sleep.
- R7: The comparator reference is captured at sleep entry. While asleep with cmp_wake_en=1, a comparator output that differs from it sets cmp_wake_flag and wakes the core with wake_cause=4. With cmp_wake_en=0 it is ignored.
- R8: On wake, osc_en returns to 1 and wdt_clr pulses for one cycle, both in the same cycle. wake_rst is high for exactly 4 cycles starting in that cycle.
- R9: If several sources are present in the same cycle, wake_cause takes the highest-priority one (external > watchdog > pin > comparator). The pin and comparator flags are still set for every source present.
- R10: The cause code and wake flags hold through the wake reset. A flag_clr pulse clears pin_wake_flag, cmp_wake_flag and wake_cause and leaves to_flag unchanged.
- R11: Pins, comparator and ext_rst_n pass through two synchronizing flops. A change that arrives before edge k causes the wake at edge k+2. A watchdog time-out sampled at edge k causes the wake at edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sleep_req | input | 1 | One-cycle request to enter sleep |
| port_access | input | 1 | Port read or write pulse; reloads the pin reference |
| flag_clr | input | 1 | Software clear of the cause code and wake flags |
| ext_rst_n | input | 1 | External reset line, active low |
| ext_rst_en | input | 1 | External line is configured as a reset |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog time-out |
| pin_wake_en | input | 1 | Enable wake on pin change |
| pins_in | input | 3 | Monitored input pins |
| cmp_wake_en | input | 1 | Enable wake on comparator change |
| cmp_in | input | 1 | Comparator output |
| osc_en | output | 1 | Oscillator enable |
| wdt_clr | output | 1 | Watchdog clear pulse |
| wake_rst | output | 1 | Wake reset pulse to the core |
| to_flag | output | 1 | Time-out status flag (status bit 4) |
| pd_flag | output | 1 | Power-down status flag (status bit 3) |
| pin_wake_flag | output | 1 | Sticky pin wake flag |
| cmp_wake_flag | output | 1 | Sticky comparator wake flag |
| wake_cause | output | 3 | 0 none, 1 external, 2 watchdog, 3 pin, 4 comparator |

## Verification
The effects of a sleep request show one edge after it is sampled. A watchdog wake shows one edge after the time-out is sampled. A pin, comparator or external-line wake shows three edges after the change is driven, because of the two synchronizer stages plus the decision register. The wake reset stays high for four cycles from the wake edge.

The bench drives inputs at the falling edge and samples at the falling edge after the exact number of rising edges. It also samples the cycle before each wake is due, to show the wake is not early. To test same-cycle priority, the watchdog time-out is delayed by two cycles relative to the synchronized sources, so that all chosen sources reach the decision in one cycle.

// File: rtl/slp_wake_pkg.sv
package slp_wake_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_EXT  = 3'd1,
    CAUSE_WDT  = 3'd2,
    CAUSE_PIN  = 3'd3,
    CAUSE_CMP  = 3'd4
  } wake_cause_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2
  } pm_state_e;

  typedef struct packed {
    logic ext;
    logic wdt;
    logic pin;
    logic cmp;
  } wake_hits_t;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/slp_wake_detect.sv
module slp_wake_detect
  import slp_wake_pkg::*;
#(
  parameter int NPIN = 3
) (
  input  logic            in_sleep,
  input  logic            ext_en,
  input  logic            ext_n_s,
  input  logic            wdt_en,
  input  logic            wdt_to,
  input  logic            pin_en,
  input  logic [NPIN-1:0] pins_s,
  input  logic [NPIN-1:0] pin_ref,
  input  logic            cmp_en,
  input  logic            cmp_s,
  input  logic            cmp_ref,
  output wake_hits_t      hits,
  output wake_cause_e     cause,
  output logic            any
);
  always_comb begin
    hits.ext = in_sleep && ext_en && !ext_n_s;
    hits.wdt = in_sleep && wdt_en && wdt_to;
    hits.pin = in_sleep && pin_en && (pins_s != pin_ref);
    hits.cmp = in_sleep && cmp_en && (cmp_s != cmp_ref);
    any      = |hits;
    if (hits.ext)      cause = CAUSE_EXT;
    else if (hits.wdt) cause = CAUSE_WDT;
    else if (hits.pin) cause = CAUSE_PIN;
    else if (hits.cmp) cause = CAUSE_CMP;
    else               cause = CAUSE_NONE;
  end
endmodule

// File: rtl/slp_pm_seq.sv
module slp_pm_seq
  import slp_wake_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sleep_req,
  input  logic        flag_clr,
  input  wake_hits_t  hits,
  input  logic        any,
  input  wake_cause_e cause_in,
  output logic        in_run,
  output logic        in_sleep,
  output logic        osc_en,
  output logic        wdt_clr,
  output logic        wake_rst,
  output logic        to_flag,
  output logic        pd_flag,
  output logic        pin_flag,
  output logic        cmp_flag,
  output wake_cause_e cause_q
);
  localparam int CW = $clog2(RST_CYC + 1);

  pm_state_e        state;
  logic [CW-1:0]    cnt;

  assign in_run   = (state == ST_RUN);
  assign in_sleep = (state == ST_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      cnt      <= '0;
      osc_en   <= 1'b1;
      wdt_clr  <= 1'b0;
      wake_rst <= 1'b0;
      to_flag  <= 1'b1;
      pd_flag  <= 1'b1;
      pin_flag <= 1'b0;
      cmp_flag <= 1'b0;
      cause_q  <= CAUSE_NONE;
    end else begin
      wdt_clr <= 1'b0;
      if (flag_clr) begin
        pin_flag <= 1'b0;
        cmp_flag <= 1'b0;
        cause_q  <= CAUSE_NONE;
      end
      unique case (state)
        ST_RUN: begin
          if (sleep_req) begin
            state   <= ST_SLEEP;
            osc_en  <= 1'b0;
            to_flag <= 1'b1;
            pd_flag <= 1'b0;
            wdt_clr <= 1'b1;
          end
        end
        ST_SLEEP: begin
          if (any) begin
            state    <= ST_WAKE;
            osc_en   <= 1'b1;
            wdt_clr  <= 1'b1;
            wake_rst <= 1'b1;
            cnt      <= '0;
            cause_q  <= cause_in;
            if (hits.pin) pin_flag <= 1'b1;
            if (hits.cmp) cmp_flag <= 1'b1;
            if (hits.wdt) to_flag  <= 1'b0;
          end
        end
        ST_WAKE: begin
          if (cnt == CW'(RST_CYC - 1)) begin
            wake_rst <= 1'b0;
            state    <= ST_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && sleep_req) |=> (!osc_en && to_flag && !pd_flag && wdt_clr)); // R2
  AST_PD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(pd_flag)); // R2
  AST_TO_FALL_WDT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(to_flag) |-> $past(hits.wdt)); // R4
  AST_WAKE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> (wdt_clr && wake_rst)); // R8
  AST_RST_WITH_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    wake_rst |-> osc_en); // R8
  AST_EXT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep && hits.ext) |=> (cause_q == CAUSE_EXT)); // R9
  AST_ASLEEP_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    in_sleep |-> !osc_en); // R2
endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
  import slp_wake_pkg::*;
#(
  parameter int NPIN     = 3,
  parameter int SYNC_STG = 2,
  parameter int RST_CYC  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_req,
  input  logic            port_access,
  input  logic            flag_clr,
  input  logic            ext_rst_n,
  input  logic            ext_rst_en,
  input  logic            wdt_en,
  input  logic            wdt_timeout,
  input  logic            pin_wake_en,
  input  logic [NPIN-1:0] pins_in,
  input  logic            cmp_wake_en,
  input  logic            cmp_in,
  output logic            osc_en,
  output logic            wdt_clr,
  output logic            wake_rst,
  output logic            to_flag,
  output logic            pd_flag,
  output logic            pin_wake_flag,
  output logic            cmp_wake_flag,
  output logic [2:0]      wake_cause
);
  localparam int SW = NPIN + 2;
  localparam logic [SW-1:0] SYNC_RST = SW'(1) << (SW - 1);

  logic [SW-1:0]   sync_q;
  logic [NPIN-1:0] pins_s, pin_ref;
  logic            cmp_s, ext_n_s, cmp_ref;
  logic            in_run, in_sleep, any;
  wake_hits_t      hits;
  wake_cause_e     cause_c, cause_q;

  slp_sync #(.W(SW), .STAGES(SYNC_STG), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ext_rst_n, cmp_in, pins_in}), .q(sync_q)
  );
  assign pins_s  = sync_q[NPIN-1:0];
  assign cmp_s   = sync_q[NPIN];
  assign ext_n_s = sync_q[NPIN+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_ref <= '0;
      cmp_ref <= 1'b0;
    end else begin
      if (in_run && port_access) pin_ref <= pins_s;
      if (in_run && sleep_req)   cmp_ref <= cmp_s;
    end
  end

  slp_wake_detect #(.NPIN(NPIN)) u_detect (
    .in_sleep(in_sleep), .ext_en(ext_rst_en), .ext_n_s(ext_n_s),
    .wdt_en(wdt_en), .wdt_to(wdt_timeout), .pin_en(pin_wake_en),
    .pins_s(pins_s), .pin_ref(pin_ref), .cmp_en(cmp_wake_en),
    .cmp_s(cmp_s), .cmp_ref(cmp_ref), .hits(hits), .cause(cause_c), .any(any)
  );

  slp_pm_seq #(.RST_CYC(RST_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .flag_clr(flag_clr),
    .hits(hits), .any(any), .cause_in(cause_c), .in_run(in_run),
    .in_sleep(in_sleep), .osc_en(osc_en), .wdt_clr(wdt_clr),
    .wake_rst(wake_rst), .to_flag(to_flag), .pd_flag(pd_flag),
    .pin_flag(pin_wake_flag), .cmp_flag(cmp_wake_flag), .cause_q(cause_q)
  );
  assign wake_cause = cause_q;

  AST_REF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    in_sleep |=> $stable(pin_ref)); // R5
  AST_CMP_REF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep && $past(in_sleep)) |-> $stable(cmp_ref)); // R7
endmodule

// File: tb/slp_wake_ctrl_bench.sv
`timescale 1ns/1ps
module slp_wake_ctrl_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, sleep_req, port_access, flag_clr, ext_rst_n, ext_rst_en;
  logic       wdt_en, wdt_timeout, pin_wake_en, cmp_wake_en, cmp_in;
  logic [2:0] pins_in;
  logic       osc_en, wdt_clr, wake_rst, to_flag, pd_flag, pin_wake_flag, cmp_wake_flag;
  logic [2:0] wake_cause;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  slp_wake_ctrl u_slp_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .port_access(port_access),
    .flag_clr(flag_clr), .ext_rst_n(ext_rst_n), .ext_rst_en(ext_rst_en),
    .wdt_en(wdt_en), .wdt_timeout(wdt_timeout), .pin_wake_en(pin_wake_en),
    .pins_in(pins_in), .cmp_wake_en(cmp_wake_en), .cmp_in(cmp_in),
    .osc_en(osc_en), .wdt_clr(wdt_clr), .wake_rst(wake_rst), .to_flag(to_flag),
    .pd_flag(pd_flag), .pin_wake_flag(pin_wake_flag), .cmp_wake_flag(cmp_wake_flag),
    .wake_cause(wake_cause)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sleep_req = 1'b0; port_access = 1'b0; flag_clr = 1'b0;
    ext_rst_n = 1'b1; ext_rst_en = 1'b0; wdt_en = 1'b0; wdt_timeout = 1'b0;
    pin_wake_en = 1'b0; cmp_wake_en = 1'b0; cmp_in = 1'b0; pins_in = 3'b000;
    tick(3);
    rst_n = 1'b1;
    tick(3);
  endtask

  task automatic sleep_now();
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    chk("R2 osc_en off", osc_en, 0);
    chk("R2 to_flag set", to_flag, 1);
    chk("R2 pd_flag clear", pd_flag, 0);
    chk("R2 wdt_clr pulse", wdt_clr, 1);
  endtask

  initial begin
    do_reset();
    chk("R1 osc_en", osc_en, 1);
    chk("R1 pd_flag", pd_flag, 1);
    chk("R1 to_flag", to_flag, 1);
    chk("R1 wake_rst", wake_rst, 0);
    chk("R1 wdt_clr", wdt_clr, 0);
    chk("R1 pin flag", pin_wake_flag, 0);
    chk("R1 cmp flag", cmp_wake_flag, 0);
    chk("R1 cause", wake_cause, 0);

    // R9 R11 sweep over every set of simultaneous sources
    for (int m = 0; m < 16; m++) begin
      logic e, w, p, c;
      logic [2:0] exp_cause;
      e = m[3]; w = m[2]; p = m[1]; c = m[0];
      exp_cause = e ? 3'd1 : w ? 3'd2 : p ? 3'd3 : c ? 3'd4 : 3'd0;
      do_reset();
      ext_rst_en = 1'b1; wdt_en = 1'b1; pin_wake_en = 1'b1; cmp_wake_en = 1'b1;
      tick(2);
      sleep_now();
      tick();
      chk("R2 wdt_clr one cycle", wdt_clr, 0);
      if (m == 0) begin
        tick(10);
        chk("R3 R5 R7 no event stays asleep", osc_en, 0);
      end else begin
        if (e) ext_rst_n = 1'b0;
        if (p) pins_in = 3'b101;
        if (c) cmp_in = 1'b1;
        tick();
        chk("R11 not early 1", osc_en, 0);
        tick();
        chk("R11 not early 2", osc_en, 0);
        if (w) wdt_timeout = 1'b1;
        tick();
        wdt_timeout = 1'b0;
        ext_rst_n = 1'b1;
        chk("R11 wake on time", osc_en, 1);
        chk("R8 wdt_clr on wake", wdt_clr, 1);
        chk("R8 wake_rst start", wake_rst, 1);
        chk("R9 cause priority", wake_cause, exp_cause);
        chk("R5 pin flag", pin_wake_flag, p);
        chk("R7 cmp flag", cmp_wake_flag, c);
        chk("R4 to_flag", to_flag, !w);
        chk("R3 ext cause", e ? (wake_cause == 3'd1) : 1'b1, 1);
        chk("R2 pd stays clear", pd_flag, 0);
        tick();
        chk("R8 wdt_clr one cycle", wdt_clr, 0);
        chk("R8 wake_rst 2", wake_rst, 1);
        tick();
        chk("R8 wake_rst 3", wake_rst, 1);
        tick();
        chk("R8 wake_rst 4", wake_rst, 1);
        tick();
        chk("R8 wake_rst end", wake_rst, 0);
        chk("R8 osc stays on", osc_en, 1);
        chk("R10 cause held", wake_cause, exp_cause);
        chk("R10 pin flag held", pin_wake_flag, p);
        chk("R10 cmp flag held", cmp_wake_flag, c);
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
        chk("R10 cause cleared", wake_cause, 0);
        chk("R10 pin cleared", pin_wake_flag, 0);
        chk("R10 cmp cleared", cmp_wake_flag, 0);
        chk("R10 to unchanged", to_flag, !w);
      end
    end

    // R3 R4 R5 R7: disabled sources are ignored
    do_reset();
    sleep_now();
    ext_rst_n = 1'b0; pins_in = 3'b111; cmp_in = 1'b1; wdt_timeout = 1'b1;
    tick(8);
    chk("R3 R4 R5 R7 disabled ignored", osc_en, 0);
    chk("R4 to kept when disabled", to_flag, 1);
    chk("R5 R7 no flags when disabled", {pin_wake_flag, cmp_wake_flag, wake_cause}, 0);

    // R6: stale mismatch wakes immediately
    do_reset();
    pin_wake_en = 1'b1;
    pins_in = 3'b011;
    tick(3);
    sleep_now();
    tick();
    chk("R6 immediate wake", osc_en, 1);
    chk("R6 cause pin", wake_cause, 3);

    // R5: refreshed reference, then a real change
    do_reset();
    pin_wake_en = 1'b1;
    pins_in = 3'b011;
    tick(3);
    port_access = 1'b1;
    tick();
    port_access = 1'b0;
    sleep_now();
    tick(8);
    chk("R5 refreshed ref no wake", osc_en, 0);
    pins_in = 3'b111;
    tick(2);
    chk("R11 pin not early", osc_en, 0);
    tick();
    chk("R5 pin change wakes", osc_en, 1);
    chk("R5 cause pin", wake_cause, 3);

    // R7: comparator reference taken at sleep entry
    do_reset();
    cmp_wake_en = 1'b1;
    cmp_in = 1'b1;
    tick(3);
    sleep_now();
    tick(8);
    chk("R7 entry value no wake", osc_en, 0);
    cmp_in = 1'b0;
    tick(2);
    chk("R11 cmp not early", osc_en, 0);
    tick();
    chk("R7 cmp change wakes", osc_en, 1);
    chk("R7 cmp flag", cmp_wake_flag, 1);
    chk("R7 cause cmp", wake_cause, 4);

    // R4: watchdog alone, one-edge latency
    do_reset();
    wdt_en = 1'b1;
    sleep_now();
    tick(3);
    wdt_timeout = 1'b1;
    tick();
    wdt_timeout = 1'b0;
    chk("R4 wdt wake", osc_en, 1);
    chk("R4 to cleared", to_flag, 0);
    chk("R4 cause wdt", wake_cause, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule